// File: doc/BRIEF.md
# Dynamic Bus Sizing Lane Steerer

This block sits between a 32-bit internal operand path and an external big-endian data bus whose port may be 32, 16 or 8 bits wide. It accepts one byte, half-word or word request at a time and places the operand bytes on the correct byte lanes. If the port turns out to be narrower than the operand, it splits the transfer into several bus cycles and reassembles the read data into the internal operand positions.

Lane 0 is the most significant byte of the bus (`bus_wdata[31:24]`, `bus_rdata[31:24]`). Operand byte k is held at `req_wdata[31-8k -: 8]`, so byte 0 is the most significant. A narrow port always sits on the top lanes: lanes 0-1 for a 16-bit port and lane 0 for an 8-bit port. The first cycle of every request is issued as if the port were 32 bits wide. The actual width is reported by the chip-select decode together with each acknowledge, and only then does the block decide whether more cycles are needed. On a write, each byte is copied onto every lane that some port width could sample, so the data is already correct whatever width the acknowledge reports.

Top module: `bus_lane_steer`

## Requirements
- R1: Size codes are `req_size` 00 byte, 01 half-word, 10 or 11 word. A request is accepted when `req_valid` is high while `req_ready` is high. `req_ready` is high only when no transfer is in progress.
- R2: On a 32-bit port, any aligned request completes in one bus cycle at its own address. Operand byte k travels on lane k for both reads and writes.
- R3: Port codes are `port_code` 00 32-bit, 01 16-bit, 10 8-bit and 11 32-bit. On a 16-bit port, a word takes two cycles, at address A and then A+2, with the bytes on lanes 0-1. A half-word at offset 2 moves on lanes 0-1, and a byte at offset o moves on lane o mod 2.
- R4: On an 8-bit port, a word takes four cycles and a half-word takes two. The address steps by 1 each cycle, and every byte moves on lane 0.
- R5: The first bus cycle of every request presents its own address and a `bus_len` equal to the full operand byte count (1, 2 or 4), as if the port were 32 bits. `bus_len` counts the bytes still to move from `bus_addr`.
- R6: When `mem_ctl` is low, the port is treated as 32 bits whatever `port_code` says.
- R7: A misaligned request raises `err` for one cycle, in the cycle after acceptance, and starts no bus cycle and gives no `done`. A request is misaligned if it is a word, or has `req_burst` set, with address bits [1:0] nonzero, or if it is a half-word at an odd address.
- R8: `done` pulses for one cycle, in the cycle after the final acknowledge. On a read, `rdata` then holds the requested bytes in their operand positions, with every unrequested byte zero.
- R9: While `bus_cyc` is high and `bus_ack` is low, `bus_addr`, `bus_len` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand size code |
| req_burst | input | 1 | Request is part of a burst (alignment check only) |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 4*LANE_W | Write operand, byte 0 most significant |
| mem_ctl | input | 1 | Transfer governed by the internal memory controller |
| port_code | input | 2 | Port width from chip-select decode, valid with bus_ack |
| bus_ack | input | 1 | Current bus cycle acknowledged |
| bus_rdata | input | 4*LANE_W | Read lanes, lane 0 in the top byte |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Direction of the current cycle |
| bus_addr | output | ADDR_W | Address of the current cycle |
| bus_len | output | 3 | Bytes remaining from bus_addr |
| bus_wdata | output | 4*LANE_W | Steered write lanes |
| done | output | 1 | Request complete pulse |
| err | output | 1 | Misalignment pulse |
| rdata | output | 4*LANE_W | Assembled read operand |

## Verification
The sweep covers every size at every address offset, for reads and writes, under each port code with the memory controller in charge, and under two narrow codes with it not in charge. This separates the lane choice for each port width from the address stepping and the cycle count. Each port is modelled as a small byte store that drives only its own lanes and fills the rest with a marker value. A byte taken from the wrong lane on a read, or a copy missing from a write, therefore shows up as wrong data or as a disturbed neighbouring byte. Misaligned offsets and bursts are mixed into the same sweep, to show that the error path never reaches the bus, and one wait state on alternate requests shows that the cycle holds steady.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WRD2 = 2'b11
   } op_size_e;

   typedef enum logic [1:0] {
      PW_32  = 2'b00,
      PW_16  = 2'b01,
      PW_8   = 2'b10,
      PW_RSV = 2'b11
   } port_code_e;

   function automatic logic [2:0] op_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: op_bytes = 3'd1;
         SZ_HALF: op_bytes = 3'd2;
         default: op_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [2:0] port_bytes(input logic [1:0] code);
      case (code)
         PW_16:   port_bytes = 3'd2;
         PW_8:    port_bytes = 3'd1;
         default: port_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/lane_align_chk.sv
module lane_align_chk
   import lane_steer_pkg::*;
(
   input  logic [1:0] size,
   input  logic       burst,
   input  logic [1:0] off,
   output logic       misal
);
   logic word_op;
   logic half_op;

   always_comb begin
      word_op = (size == SZ_WORD) || (size == SZ_WRD2);
      half_op = (size == SZ_HALF);
      misal   = ((word_op || burst) && (off != 2'b00)) || (half_op && off[0]);
   end
endmodule

// File: rtl/lane_wr_steer.sv
module lane_wr_steer #(
   parameter int LANE_W = 8
) (
   input  logic [4*LANE_W-1:0] wdata,
   input  logic [1:0]          cur,
   output logic [4*LANE_W-1:0] lanes
);
   localparam int DW = 4 * LANE_W;

   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic [1:0] sel;
      if (g == 0) begin : g_l0
         assign sel = cur;
      end else if (g == 1) begin : g_l1
         assign sel = {cur[1], 1'b1};
      end else begin : g_lhi
         assign sel = 2'(g);
      end
      assign lanes[DW-1-g*LANE_W -: LANE_W] = wdata[DW-1-int'(sel)*LANE_W -: LANE_W];
   end
endmodule

// File: rtl/lane_rd_gather.sv
module lane_rd_gather #(
   parameter int LANE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                cap,
   input  logic [1:0]          cur,
   input  logic [2:0]          end_off,
   input  logic [2:0]          pbytes,
   input  logic [4*LANE_W-1:0] bus_rdata,
   output logic [4*LANE_W-1:0] rdata,
   output logic [2:0]          next_off
);
   localparam int DW = 4 * LANE_W;

   logic [1:0] base;
   logic [2:0] chunk_end;

   always_comb begin
      case (pbytes)
         3'd2:    base = {cur[1], 1'b0};
         3'd1:    base = cur;
         default: base = 2'b00;
      endcase
      chunk_end = {1'b0, base} + pbytes;
      next_off  = (end_off < chunk_end) ? end_off : chunk_end;
   end

   for (genvar k = 0; k < 4; k++) begin : g_byte
      logic [1:0] lidx;
      logic       hit;
      assign lidx = 2'(3'(k) - {1'b0, base});
      assign hit  = cap && (3'(k) >= {1'b0, cur}) && (3'(k) < next_off);
      always_ff @(posedge clk) begin
         if (!rst_n || clr) begin
            rdata[DW-1-k*LANE_W -: LANE_W] <= '0;
         end else if (hit) begin
            rdata[DW-1-k*LANE_W -: LANE_W] <= bus_rdata[DW-1-int'(lidx)*LANE_W -: LANE_W];
         end
      end
   end

   // R4
   prog_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap |-> (next_off > {1'b0, cur}));
endmodule

// File: rtl/bus_lane_steer.sv
module bus_lane_steer
   import lane_steer_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LANE_W    = 8,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [1:0]          req_size,
   input  logic                req_burst,
   input  logic                req_write,
   input  logic [4*LANE_W-1:0] req_wdata,
   input  logic                mem_ctl,
   input  logic [1:0]          port_code,
   input  logic                bus_ack,
   input  logic [4*LANE_W-1:0] bus_rdata,
   output logic                bus_cyc,
   output logic                bus_write,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [2:0]          bus_len,
   output logic [4*LANE_W-1:0] bus_wdata,
   output logic                done,
   output logic                err,
   output logic [4*LANE_W-1:0] rdata
);
   localparam int DW = 4 * LANE_W;
   localparam int BW = ADDR_W - 2;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("bus_lane_steer: ADDR_W must be at least 3");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("bus_lane_steer: LANE_W must be at least 1");
   end

   logic          busy_q, done_q, err_q, wr_q;
   logic [1:0]    cur_q;
   logic [2:0]    end_q;
   logic [BW-1:0] base_q;
   logic [DW-1:0] wdata_q;
   logic          accept, misal, cap, last;
   logic [2:0]    pbytes, next_off;

   assign accept = req_valid && !busy_q;

   lane_align_chk u_align (
      .size  (req_size),
      .burst (req_burst),
      .off   (req_addr[1:0]),
      .misal (misal)
   );

   if (NARROW_EN) begin : g_narrow
      assign pbytes = mem_ctl ? port_bytes(port_code) : 3'd4;
   end else begin : g_wide
      assign pbytes = 3'd4;
   end

   assign cap  = busy_q && bus_ack && !wr_q;
   assign last = (next_off == end_q);

   lane_rd_gather #(.LANE_W(LANE_W)) u_gather (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (accept),
      .cap       (cap),
      .cur       (cur_q),
      .end_off   (end_q),
      .pbytes    (pbytes),
      .bus_rdata (bus_rdata),
      .rdata     (rdata),
      .next_off  (next_off)
   );

   lane_wr_steer #(.LANE_W(LANE_W)) u_steer (
      .wdata (wdata_q),
      .cur   (cur_q),
      .lanes (bus_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         wr_q    <= 1'b0;
         cur_q   <= '0;
         end_q   <= '0;
         base_q  <= '0;
         wdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            if (misal) begin
               err_q <= 1'b1;
            end else begin
               busy_q  <= 1'b1;
               cur_q   <= req_addr[1:0];
               end_q   <= {1'b0, req_addr[1:0]} + op_bytes(req_size);
               base_q  <= req_addr[ADDR_W-1:2];
               wr_q    <= req_write;
               wdata_q <= req_wdata;
            end
         end else if (busy_q && bus_ack) begin
            cur_q <= next_off[1:0];
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign req_ready = !busy_q;
   assign bus_cyc   = busy_q;
   assign bus_write = wr_q;
   assign bus_addr  = {base_q, cur_q};
   assign bus_len   = end_q - {1'b0, cur_q};
   assign done      = done_q;
   assign err       = err_q;

   // R7
   misal_no_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && misal) |=> (err && !bus_cyc && !done));
   // R8
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(bus_cyc && bus_ack) && !bus_cyc));
   // R9
   cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_len) && $stable(bus_wdata)));
   // R5
   first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !misal) |=> (bus_cyc && bus_len == op_bytes($past(req_size)) && bus_addr == $past(req_addr)));
   // R1
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> !req_ready);
   // R7
   err_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err && done));
endmodule

// File: tb/bus_lane_steer_test.sv
`timescale 1ns/1ps
module bus_lane_steer_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_burst, req_write, mem_ctl, bus_ack;
   logic [31:0] req_addr, req_wdata, bus_rdata;
   logic [1:0]  req_size, port_code;
   logic        req_ready, bus_cyc, bus_write, done, err;
   logic [31:0] bus_addr, bus_wdata, rdata;
   logic [2:0]  bus_len;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #4 clk = ~clk;

   bus_lane_steer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_burst(req_burst),
      .req_write(req_write), .req_wdata(req_wdata), .mem_ctl(mem_ctl),
      .port_code(port_code), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .bus_cyc(bus_cyc), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_len(bus_len), .bus_wdata(bus_wdata), .done(done), .err(err),
      .rdata(rdata)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bench-side port model and transaction context
   logic [7:0]  mem [4];
   int          t_p, t_n, cyc_n;
   logic [31:0] t_a;
   bit          wait_cfg, holding;
   logic [31:0] hold_addr;

   function automatic logic [7:0] lane_of(input logic [31:0] v, input int l);
      return v[31-8*l -: 8];
   endfunction

   task automatic serve();
      int          off, base;
      logic [31:0] exp_a, rd;
      off   = int'(bus_addr[1:0]);
      base  = off & ~(t_p - 1);
      exp_a = (cyc_n == 0) ? t_a : ((t_a & ~32'(t_p - 1)) + 32'(cyc_n * t_p));
      // R3 R4: narrow ports step through the operand
      check(bus_addr == exp_a, "R3/R4 address", bus_addr, exp_a);
      // R5
      if (cyc_n == 0) check(int'(bus_len) == t_n, "R5 first len", bus_len, t_n);
      rd = 32'hEEEE_EEEE;
      for (int l = 0; l < t_p; l++) begin
         int idx;
         idx = base + l;
         rd[31-8*l -: 8] = mem[idx];
         if (bus_write && idx >= off && idx < off + int'(bus_len))
            mem[idx] = lane_of(bus_wdata, l);
      end
      bus_rdata = rd;
      cyc_n++;
   endtask

   initial begin
      bus_ack = 1'b0;
      bus_rdata = 32'hEEEE_EEEE;
      holding = 1'b0;
      forever begin
         @(negedge clk);
         bus_ack = 1'b0;
         bus_rdata = 32'hEEEE_EEEE;
         if (bus_cyc) begin
            if (!holding && wait_cfg) begin
               holding = 1'b1;
               hold_addr = bus_addr;
            end else begin
               // R9
               if (holding) check(bus_addr == hold_addr, "R9 hold", bus_addr, hold_addr);
               holding = 1'b0;
               serve();
               bus_ack = 1'b1;
            end
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      end
   end

   task automatic run_txn(input int code, input bit mc, input int sz, input int off,
                          input bit wr, input bit burst, input int seed);
      logic [7:0]  orig [4];
      logic [31:0] wd, exp_r;
      int          nb, exp_cyc, k;
      bit          bad, got_done, got_err;
      nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      t_p = !mc ? 4 : (code == 1) ? 2 : (code == 2) ? 1 : 4;
      t_n = nb;
      t_a = 32'h0000_1230 + 32'(off);
      cyc_n = 0;
      wait_cfg = seed[0];
      bad = ((nb == 4 || burst) && off != 0) || (nb == 2 && off[0]);
      wd = 32'hC3A5_5A3C ^ (32'(seed) * 32'h0101_0101);
      for (int i = 0; i < 4; i++) begin
         mem[i]  = 8'(seed * 7 + i * 17 + 3);
         orig[i] = mem[i];
      end
      @(negedge clk);
      req_valid = 1'b1; req_addr = t_a; req_size = 2'(sz); req_burst = burst;
      req_write = wr; req_wdata = wd; mem_ctl = mc; port_code = 2'(code);
      @(negedge clk);
      req_valid = 1'b0;
      got_done = 1'b0; got_err = err;
      // R10-like readiness: R1
      if (!bad) check(!req_ready && bus_cyc, "R1 busy after accept", req_ready, 0);
      k = 0;
      while (!bad && !done && k < 60) begin
         @(negedge clk);
         k++;
      end
      got_done = done;
      if (bad) begin
         // R7
         check(got_err && !bus_cyc && !done, "R7 misalign err", {got_err, bus_cyc, done}, 3'b100);
         @(negedge clk);
         check(cyc_n == 0 && !done && !err, "R7 no cycle", cyc_n, 0);
         return;
      end
      check(got_done, "R8 done", got_done, 1);
      exp_cyc = (nb > t_p) ? nb / t_p : 1;
      // R2 R3 R4 R6: cycle count per port width
      check(cyc_n == exp_cyc, (mc ? "R2/R3/R4 cycles" : "R6 wide when mem_ctl low"), cyc_n, exp_cyc);
      exp_r = 32'h0;
      for (int i = 0; i < 4; i++) begin
         if (i >= off && i < off + nb) exp_r[31-8*i -: 8] = orig[i];
      end
      if (!wr) begin
         // R8: requested bytes in place, others zero
         check(rdata == exp_r, "R8 read assembly", rdata, exp_r);
      end else begin
         for (int i = 0; i < 4; i++) begin
            logic [7:0] e;
            e = (i >= off && i < off + nb) ? wd[31-8*i -: 8] : orig[i];
            check(mem[i] == e, "R2/R3/R4 write lanes", mem[i], e);
         end
      end
      @(negedge clk);
      check(!done && req_ready, "R8 single done pulse", done, 0);
   endtask

   initial begin
      int seed;
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_burst = 1'b0;
      req_write = 1'b0; req_wdata = '0; mem_ctl = 1'b1; port_code = '0;
      wait_cfg = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready && !bus_cyc && !done && !err && rdata == 0, "R1 reset state",
            {req_ready, bus_cyc, done, err}, 4'b1000);
      seed = 1;
      for (int cfg = 0; cfg < 6; cfg++) begin
         int  code;
         bit  mc;
         code = (cfg < 4) ? cfg : cfg - 3;
         mc   = (cfg < 4);
         for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 4; off++) begin
               for (int wr = 0; wr < 2; wr++) begin
                  run_txn(code, mc, sz, off, wr[0], 1'b0, seed);
                  seed++;
               end
            end
         end
      end
      // R7 burst alignment: aligned byte burst works, offset burst rejected
      run_txn(2, 1'b1, 0, 0, 1'b0, 1'b1, seed); seed++;
      run_txn(2, 1'b1, 0, 2, 1'b0, 1'b1, seed); seed++;
      run_txn(1, 1'b1, 2, 0, 1'b1, 1'b1, seed); seed++;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule